// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Flag

This block performs one shift or rotate on an operand of 8, 16 or 32 bits held in the low part of a 32-bit word, and produces the new word together with five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It covers eight operations. There are logical and arithmetic shifts in both directions, and rotates in both directions. The rotates come in two kinds: a plain rotate keeps its bits inside the operand, and an extend rotate treats the incoming X flag as one more bit of a ring of 9, 17 or 33 bits.

A request is presented with `in_vld` high for one cycle, along with the operation, the size, a 6-bit count and the current X flag. On the next cycle `out_vld` is high, and the registered result and flags stay stable until the next request. Bits of the word above the selected size come out exactly as they went in. N and Z describe only the selected size.

Top module: `sru_unit`

## Requirements
- R1: The operation code `in_op` is encoded as 0 logical left, 1 logical right, 2 arithmetic left, 3 arithmetic right, 4 rotate left, 5 rotate right, 6 extend-rotate left, 7 extend-rotate right. The size code `in_size` is 0 byte, 1 word, 2 long and 3 long. Logical shifts fill vacated positions with zero, and arithmetic left gives the same result as logical left.
- R2: An arithmetic right shift fills the vacated high bits with copies of the operand's sign bit.
- R3: Plain rotates move bits only within the operand of the selected size, and they leave X unchanged.
- R4: Extend rotates rotate the ring formed by X and the operand. The bit leaving the operand becomes the new X, and the old X enters at the other end.
- R5: C equals the last bit shifted or rotated out. With a count of zero, C is 0 for shifts and plain rotates.
- R6: With a count of zero, an extend rotate sets C to the incoming X and leaves the result and X unchanged.
- R7: For shifts and extend rotates with a nonzero count, X equals the last bit moved out. A count of zero leaves X unchanged.
- R8: V is 1 only for an arithmetic left shift in which the operand's top bit took more than one value during the shift. For every other operation V is 0.
- R9: N is the top bit of the result at the selected size, and Z is 1 when the result at that size is all zero. Bits of `in_data` above the size appear unchanged in `out_data`.
- R10: Any count from 0 to 63 is valid. Shifts by more than the width give zero, or all copies of the sign bit for an arithmetic right shift. Plain rotates repeat with period W, and extend rotates repeat with period W+1.
- R11: `out_vld` is high exactly in the cycle after `in_vld`. Outputs hold their values while no request arrives, and reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (see R1) |
| in_size | input | 2 | Operand size code (see R1) |
| in_cnt | input | 6 | Shift or rotate count |
| in_data | input | 32 | Operand word |
| in_x | input | 1 | Incoming extend flag |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_data | output | 32 | Result word |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The only internal state is the output register. If that register captured the wrong size lane or went stale, the error would appear at the ports in the very next valid cycle, as a wrong upper slice or wrong N/Z values. A modulo error in the rotate amount shows up only at counts at or above the operand width. A misplaced ring position for X shows up only in extend rotates with the two X values compared. For these reasons the sweep covers every count from 0 to 63 for every size, operation and both X values, and compares each result against a bit-by-bit reference.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        OP_LSL  = 3'd0,
        OP_LSR  = 3'd1,
        OP_ASL  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_ROXL = 3'd6,
        OP_ROXR = 3'd7
    } sru_op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } sru_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        sru_flags_t        fl;
    } sru_out_t;

endpackage

// File: rtl/sru_lane.sv
module sru_lane
    import sru_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     a,
    input  logic [CNT_W-1:0] cnt,
    input  sru_op_e          op,
    input  logic             x_in,
    output logic [W-1:0]     res,
    output logic             c_out,
    output logic             x_out,
    output logic             v_out
);
    localparam int RW = W + 1;
    localparam logic [CNT_W-1:0] W_C  = CNT_W'(W);
    localparam logic [CNT_W-1:0] RW_C = CNT_W'(RW);

    logic              zero_cnt;
    logic [CNT_W-1:0]  rot_amt;
    logic [CNT_W-1:0]  ext_amt;
    logic [W:0]        lsl_t;
    logic [W:0]        lsr_t;
    logic signed [W:0] asr_t;
    logic [W-1:0]      asl_back;
    logic [W-1:0]      rol_r;
    logic [W-1:0]      ror_r;
    logic [RW-1:0]     ring;
    logic [RW-1:0]     roxl_r;
    logic [RW-1:0]     roxr_r;

    assign zero_cnt = (cnt == '0);
    assign rot_amt  = cnt % W_C;
    assign ext_amt  = cnt % RW_C;

    // Shifts carry one guard bit that catches the last bit moved out
    assign lsl_t    = {1'b0, a} << cnt;
    assign lsr_t    = {a, 1'b0} >> cnt;
    assign asr_t    = $signed({a, 1'b0}) >>> cnt;

    // Top bit never moved iff shifting back arithmetically restores a
    assign asl_back = $signed(lsl_t[W-1:0]) >>> cnt;

    assign rol_r    = (a << rot_amt) | (a >> (W_C - rot_amt));
    assign ror_r    = (a >> rot_amt) | (a << (W_C - rot_amt));

    assign ring     = {x_in, a};
    assign roxl_r   = (ring << ext_amt) | (ring >> (RW_C - ext_amt));
    assign roxr_r   = (ring >> ext_amt) | (ring << (RW_C - ext_amt));

    always_comb begin
        res   = a;
        c_out = 1'b0;
        x_out = x_in;
        v_out = 1'b0;
        unique case (op)
            OP_LSL, OP_ASL: begin
                res   = lsl_t[W-1:0];
                c_out = lsl_t[W];
                x_out = zero_cnt ? x_in : lsl_t[W];
                v_out = (op == OP_ASL) && (asl_back != a);
            end
            OP_LSR: begin
                res   = lsr_t[W:1];
                c_out = lsr_t[0];
                x_out = zero_cnt ? x_in : lsr_t[0];
            end
            OP_ASR: begin
                res   = asr_t[W:1];
                c_out = asr_t[0];
                x_out = zero_cnt ? x_in : asr_t[0];
            end
            OP_ROL: begin
                res   = rol_r;
                c_out = !zero_cnt && rol_r[0];
            end
            OP_ROR: begin
                res   = ror_r;
                c_out = !zero_cnt && ror_r[W-1];
            end
            OP_ROXL: begin
                res   = roxl_r[W-1:0];
                c_out = roxl_r[W];
                x_out = roxl_r[W];
            end
            OP_ROXR: begin
                res   = roxr_r[W-1:0];
                c_out = roxr_r[W];
                x_out = roxr_r[W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sru_pick.sv
module sru_pick
    import sru_pkg::*;
#(
    parameter int NUM_LANES = 3
) (
    input  logic [1:0]                 size,
    input  sru_out_t [NUM_LANES-1:0]   lanes,
    output sru_out_t                   sel
);
    int idx;

    always_comb begin
        idx = int'(size);
        if (idx > NUM_LANES - 1) idx = NUM_LANES - 1;
        sel = lanes[idx];
    end

endmodule

// File: rtl/sru_unit.sv
module sru_unit
    import sru_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [2:0]    in_op,
    input  logic [1:0]    in_size,
    input  logic [CW-1:0] in_cnt,
    input  logic [DW-1:0] in_data,
    input  logic          in_x,
    output logic          out_vld,
    output logic [DW-1:0] out_data,
    output logic          out_x,
    output logic          out_n,
    output logic          out_z,
    output logic          out_v,
    output logic          out_c
);
    localparam int NUM_LANES = $clog2(DW / 8) + 1;

    sru_op_e                  op;
    sru_out_t [NUM_LANES-1:0] lane_out;
    sru_out_t                 picked;
    sru_out_t                 out_q;
    logic                     vld_q;

    assign op = sru_op_e'(in_op);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = 8 << g;
        localparam logic [DW-1:0] LOW_MASK = DW'((64'h1 << LW) - 64'h1);

        logic [LW-1:0] lres;
        logic          lc, lx, lv;
        logic [DW-1:0] merged;

        sru_lane #(.W(LW), .CNT_W(CW)) u_lane (
            .a     (in_data[LW-1:0]),
            .cnt   (in_cnt),
            .op    (op),
            .x_in  (in_x),
            .res   (lres),
            .c_out (lc),
            .x_out (lx),
            .v_out (lv)
        );

        assign merged      = (in_data & ~LOW_MASK) | DW'(lres);
        assign lane_out[g] = '{res: merged,
                               fl: '{x: lx, n: lres[LW-1], z: (lres == '0),
                                     v: lv, c: lc}};
    end

    sru_pick #(.NUM_LANES(NUM_LANES)) u_pick (
        .size  (in_size),
        .lanes (lane_out),
        .sel   (picked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            out_q <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) out_q <= picked;
        end
    end

    assign out_vld  = vld_q;
    assign out_data = out_q.res;
    assign out_x    = out_q.fl.x;
    assign out_n    = out_q.fl.n;
    assign out_z    = out_q.fl.z;
    assign out_v    = out_q.fl.v;
    assign out_c    = out_q.fl.c;

    logic is_rox;
    assign is_rox = (in_op == 3'd6) || (in_op == 3'd7);

    assert_vld_rise_R11: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    assert_vld_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld && $stable(out_data));
    assert_rot_keeps_x_R3: assert property (@(posedge clk) disable iff (rst)
        in_vld && (in_op == 3'd4 || in_op == 3'd5) |=> out_x == $past(in_x));
    assert_v_only_asl_R8: assert property (@(posedge clk) disable iff (rst)
        in_vld && (in_op != 3'd2) |=> !out_v);
    assert_zero_cnt_c_R5: assert property (@(posedge clk) disable iff (rst)
        in_vld && (in_cnt == '0) && !is_rox |=> !out_c && out_x == $past(in_x));
    assert_ext_zero_c_R6: assert property (@(posedge clk) disable iff (rst)
        in_vld && (in_cnt == '0) && is_rox |=> out_c == $past(in_x));
    assert_upper_pass_R9: assert property (@(posedge clk) disable iff (rst)
        in_vld && (in_size == 2'd0) |=> out_data[DW-1:8] == $past(in_data[DW-1:8]));

endmodule

// File: tb/sru_unit_tb.sv
module sru_unit_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [2:0]  in_op = '0;
    logic [1:0]  in_size = '0;
    logic [5:0]  in_cnt = '0;
    logic [31:0] in_data = '0;
    logic        in_x = 1'b0;
    logic        out_vld;
    logic [31:0] out_data;
    logic        out_x, out_n, out_z, out_v, out_c;

    int n_checks = 0;
    int n_errs   = 0;

    always #(CLK_P/2) clk = ~clk;

    sru_unit dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_op(in_op), .in_size(in_size),
        .in_cnt(in_cnt), .in_data(in_data), .in_x(in_x), .out_vld(out_vld),
        .out_data(out_data), .out_x(out_x), .out_n(out_n), .out_z(out_z),
        .out_v(out_v), .out_c(out_c)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-by-bit reference, one step per count
    task automatic model(input int op, input int sz, input logic [31:0] d,
                         input logic xi, input int n, output logic [31:0] r,
                         output logic c, output logic x, output logic v,
                         output logic nf, output logic zf);
        int w;
        logic [31:0] mask, a;
        logic o;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        a = d & mask; c = 1'b0; x = xi; v = 1'b0;
        for (int k = 0; k < n; k++) begin
            case (op)
                0, 2: begin o = a[w-1]; a = (a << 1) & mask; c = o; x = o;
                            if (a[w-1] != o && op == 2) v = 1'b1; end
                1: begin o = a[0]; a = a >> 1; c = o; x = o; end
                3: begin o = a[0]; a = (a >> 1) | ({31'b0, a[w-1]} << (w-1)); c = o; x = o; end
                4: begin o = a[w-1]; a = ((a << 1) | {31'b0, o}) & mask; c = o; end
                5: begin o = a[0]; a = (a >> 1) | ({31'b0, o} << (w-1)); c = o; end
                6: begin o = a[w-1]; a = ((a << 1) | {31'b0, x}) & mask; x = o; c = o; end
                default: begin o = a[0]; a = (a >> 1) | ({31'b0, x} << (w-1)); x = o; c = o; end
            endcase
        end
        if (n == 0 && op >= 6) c = xi;
        r = (d & ~mask) | a;
        nf = a[w-1];
        zf = (a == 32'h0);
    endtask

    logic [31:0] pats [8];

    initial begin
        logic [31:0] er;
        logic ec, ex, ev, en, ez;
        string rtag, ctag;
        int w;
        pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hC3A5_5A81, 32'h7E01_8F36,
                 32'h8000_8080, 32'h0000_0001, 32'h1234_4321, 32'h5A5A_A5A5};
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(out_vld == 1'b0, "R11 reset vld", {31'b0, out_vld}, 32'h0);
        chk(out_data == 32'h0, "R11 reset data", out_data, 32'h0);
        chk({out_x, out_n, out_z, out_v, out_c} == 5'b0, "R11 reset flags",
            {27'b0, out_x, out_n, out_z, out_v, out_c}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int sz = 0; sz < 4; sz++)
        for (int op = 0; op < 8; op++)
        for (int di = 0; di < 8; di++)
        for (int xi = 0; xi < 2; xi++)
        for (int n = 0; n < 64; n++) begin
            in_vld = 1'b1; in_op = 3'(op); in_size = 2'(sz); in_cnt = 6'(n);
            in_data = pats[di]; in_x = xi[0];
            @(negedge clk);
            model(op, sz, pats[di], xi[0], n, er, ec, ex, ev, en, ez);
            w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
            if (n > w) rtag = "R10 result";
            else if (op <= 2) rtag = "R1 result";
            else if (op == 3) rtag = "R2 result";
            else if (op <= 5) rtag = "R3 result";
            else rtag = "R4 result";
            ctag = (n == 0 && op >= 6) ? "R6 carry" : "R5 carry";
            chk(out_vld == 1'b1, "R11 valid", {31'b0, out_vld}, 32'h1);
            chk(out_data == er, rtag, out_data, er);
            chk(out_c == ec, ctag, {31'b0, out_c}, {31'b0, ec});
            chk(out_x == ex, "R7 extend", {31'b0, out_x}, {31'b0, ex});
            chk(out_v == ev, "R8 overflow", {31'b0, out_v}, {31'b0, ev});
            chk({out_n, out_z} == {en, ez}, "R9 n/z", {30'b0, out_n, out_z},
                {30'b0, en, ez});
        end

        // R11: idle cycles hold the last result
        in_vld = 1'b1; in_op = 3'd4; in_size = 2'd2; in_cnt = 6'd8;
        in_data = 32'h1234_5678; in_x = 1'b0;
        @(negedge clk);
        in_vld = 1'b0; in_data = 32'hDEAD_BEEF; in_op = 3'd0;
        chk(out_data == 32'h3456_7812, "R11 rotate before idle", out_data, 32'h3456_7812);
        @(negedge clk);
        chk(out_vld == 1'b0, "R11 idle vld", {31'b0, out_vld}, 32'h0);
        chk(out_data == 32'h3456_7812, "R11 idle hold", out_data, 32'h3456_7812);
        @(negedge clk);
        chk(out_data == 32'h3456_7812, "R11 idle hold 2", out_data, 32'h3456_7812);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule